// File: doc/BRIEF.md
# Floppy Sector Command Validator

This block sits on the command path of a floppy disk controller. When a command byte is strobed in, it takes the current track and sector register values and the head select, and checks the cylinder/head/sector triple against a disk geometry held in configuration registers. A valid read-sector request yields a zero-based logical block number and a start request toward the media engine. A request that falls outside the disk is turned away with a record-not-found status, and no transfer starts.

During a transfer the block counts data-register reads against a byte length derived from the sector count. It presents a data-request bit in the status byte while bytes remain, moves the logical block number on at each sector boundary of a multi-sector command, and raises an interrupt at completion. Commands that move no data complete at once. Their busy bit is dropped by the first status read.

Top module: `sector_cmd_check`

## Requirements
- R1: A read-sector command is a command byte whose bits 7:5 are 100. Its head number is bit 1 of the command byte. An accepted request pulses `start_o` one cycle after the strobe, with `lba_o` = track*heads*spt + head*spt + sector - 1.
- R2: A read request whose track is greater than or equal to the configured track count is rejected.
- R3: A read request whose head number is greater than or equal to the configured head count is rejected.
- R4: A read request whose sector is zero or greater than sectors-per-track is rejected. Any rejection sets the status to 0x10 (bit 4, record not found) and gives no `start_o` pulse.
- R5: Every command clears the byte position. An accepted read sets the length to BYTES_PER_SEC for a single sector. When bit 4 of the command is set, the length is (spt - sector + 1) * BYTES_PER_SEC. Each `data_rd` advances the position by one until it reaches the length. Further reads have no effect.
- R6: While a read transfer is active, status bit 1 (data request) is 1 exactly while position < length, and status bit 0 reads as 0. Status is 0x02 during the transfer and 0x00 once it completes. Bit 6 is always 0.
- R7: In a multi-sector read, `lba_o` rises by one and `start_o` pulses each time the position crosses into the next sector.
- R8: Completion raises `irq_o`. A rejection and a command with no data transfer also count as completion. `irq_new_o` pulses for one cycle only if `irq_o` was low before. Only `stat_rd` clears `irq_o`.
- R9: A command whose bits 7:5 are not 100 moves no data. It sets the status to 0x01 (bit 0, busy) and completes at once. A later `stat_rd` clears bit 0.
- R10: Geometry writes on `cfg_we` take effect when no transfer is in progress. They are ignored while a transfer still has bytes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Geometry write strobe |
| cfg_tracks | input | TRK_W | Number of tracks |
| cfg_heads | input | HEAD_W | Number of heads |
| cfg_spt | input | SEC_W | Sectors per track |
| cmd_stb | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| trk_reg | input | TRK_W | Current track register |
| sec_reg | input | SEC_W | Current sector register |
| data_rd | input | 1 | Data register read strobe |
| stat_rd | input | 1 | Status register read strobe |
| status_o | output | 8 | Status byte as read |
| lba_o | output | LBA_W | Logical block number of the current sector |
| start_o | output | 1 | One-cycle sector start request |
| irq_o | output | 1 | Interrupt line |
| irq_new_o | output | 1 | One-cycle flag for a fresh interrupt edge |

## Verification
The bench aims at the edges of the geometry:
- The last track, head and sector are accepted. One past each is rejected, and so is sector zero. A design with an off-by-one compare would either start a transfer on a missing sector or refuse the final sector of the disk.
- A multi-sector read that ends on the last sector of a track is checked for the second start pulse and the stepped block number. A design that miscounted would stop early or issue a stray request.
- Two completions without a status read in between show whether a second interrupt edge is wrongly flagged.
- A geometry write made mid-transfer shows whether limits change under a running command.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_DRQ  = 1;
  localparam int ST_RNF  = 4;
  localparam logic [2:0] OPC_READ = 3'b100;

  function automatic logic is_read_cmd(input logic [7:0] cmd);
    return cmd[7:5] == OPC_READ;
  endfunction

  function automatic logic [7:0] status_bit(input int pos);
    return 8'(1) << pos;
  endfunction
endpackage

// File: rtl/geom_regs.sv
module geom_regs #(
  parameter int TRK_W  = 8,
  parameter int HEAD_W = 2,
  parameter int SEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              busy,
  input  logic [TRK_W-1:0]  tracks_d,
  input  logic [HEAD_W-1:0] heads_d,
  input  logic [SEC_W-1:0]  spt_d,
  output logic [TRK_W-1:0]  tracks_q,
  output logic [HEAD_W-1:0] heads_q,
  output logic [SEC_W-1:0]  spt_q
);
  logic take;
  assign take = we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tracks_q <= '0;
      heads_q  <= '0;
      spt_q    <= '0;
    end else if (take) begin
      tracks_q <= tracks_d;
      heads_q  <= heads_d;
      spt_q    <= spt_d;
    end
  end

  // R10: limits stay put while a transfer still has bytes pending
  a_r10_geom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tracks_q) && $stable(heads_q) && $stable(spt_q)));
endmodule

// File: rtl/chs_check.sv
module chs_check #(
  parameter int TRK_W  = 8,
  parameter int HEAD_W = 2,
  parameter int SEC_W  = 8,
  parameter int LBA_W  = 20
) (
  input  logic [TRK_W-1:0]  trk,
  input  logic [HEAD_W-1:0] head,
  input  logic [SEC_W-1:0]  sec,
  input  logic              multi,
  input  logic [TRK_W-1:0]  g_tracks,
  input  logic [HEAD_W-1:0] g_heads,
  input  logic [SEC_W-1:0]  g_spt,
  output logic              trk_bad,
  output logic              head_bad,
  output logic              sec_bad,
  output logic              ok,
  output logic [LBA_W-1:0]  lba_base,
  output logic [SEC_W:0]    nsec
);
  function automatic logic [LBA_W-1:0] calc_lba(
    input logic [TRK_W-1:0] t, input logic [HEAD_W-1:0] h, input logic [SEC_W-1:0] s,
    input logic [HEAD_W-1:0] nh, input logic [SEC_W-1:0] ns);
    logic [LBA_W-1:0] per_cyl;
    per_cyl = LBA_W'(nh) * LBA_W'(ns);
    return LBA_W'(t) * per_cyl + LBA_W'(h) * LBA_W'(ns) + LBA_W'(s) - LBA_W'(1);
  endfunction

  function automatic logic [SEC_W:0] sectors_left(
    input logic [SEC_W-1:0] s, input logic [SEC_W-1:0] ns, input logic m);
    return m ? ((SEC_W+1)'(ns) - (SEC_W+1)'(s) + (SEC_W+1)'(1)) : (SEC_W+1)'(1);
  endfunction

  assign trk_bad  = trk >= g_tracks;
  assign head_bad = head >= g_heads;
  assign sec_bad  = (sec == '0) || (sec > g_spt);
  assign ok       = !(trk_bad || head_bad || sec_bad);
  assign lba_base = calc_lba(trk, head, sec, g_heads, g_spt);
  assign nsec     = sectors_left(sec, g_spt, multi);
endmodule

// File: rtl/xfer_track.sv
module xfer_track #(
  parameter int SEC_W         = 8,
  parameter int BYTES_PER_SEC = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_cmd,
  input  logic             load,
  input  logic [SEC_W:0]   nsec,
  input  logic             rd,
  output logic             drq,
  output logic             last_rd,
  output logic             step_rd,
  output logic [SEC_W:0]   sec_idx
);
  localparam int SHIFT = $clog2(BYTES_PER_SEC);
  localparam int PW    = SEC_W + 1 + SHIFT;
  localparam logic [PW-1:0] SEC_MASK = PW'(BYTES_PER_SEC - 1);

  logic [PW-1:0] pos_q, len_q, pos_nx;
  logic          take_rd;

  assign drq     = pos_q < len_q;
  assign take_rd = rd && drq && !new_cmd;
  assign pos_nx  = pos_q + PW'(1);
  assign last_rd = take_rd && (pos_nx == len_q);
  assign step_rd = take_rd && !last_rd && ((pos_nx & SEC_MASK) == '0);

  always_comb begin
    if (!drq && len_q != '0) sec_idx = (SEC_W+1)'((len_q >> SHIFT) - PW'(1));
    else                     sec_idx = (SEC_W+1)'(pos_q >> SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (new_cmd) begin
      pos_q <= '0;
      len_q <= load ? (PW'(nsec) << SHIFT) : '0;
    end else if (take_rd) begin
      pos_q <= pos_nx;
    end
  end

  // R5: position never runs past the length
  a_r5_pos_le_len: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= len_q);
  // R5: a read with nothing pending leaves the position alone
  a_r5_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !drq && !new_cmd) |=> $stable(pos_q));
endmodule

// File: rtl/sector_cmd_check.sv
module sector_cmd_check
  import fsv_pkg::*;
#(
  parameter int TRK_W         = 8,
  parameter int HEAD_W        = 2,
  parameter int SEC_W         = 8,
  parameter int LBA_W         = 20,
  parameter int BYTES_PER_SEC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TRK_W-1:0]  cfg_tracks,
  input  logic [HEAD_W-1:0] cfg_heads,
  input  logic [SEC_W-1:0]  cfg_spt,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_byte,
  input  logic [TRK_W-1:0]  trk_reg,
  input  logic [SEC_W-1:0]  sec_reg,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [7:0]        status_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic              start_o,
  output logic              irq_o,
  output logic              irq_new_o
);
  logic [TRK_W-1:0]  g_tracks;
  logic [HEAD_W-1:0] g_heads;
  logic [SEC_W-1:0]  g_spt;
  logic              trk_bad, head_bad, sec_bad, chs_ok;
  logic [LBA_W-1:0]  lba_base;
  logic [SEC_W:0]    nsec, sec_idx;
  logic              drq, last_rd, step_rd;
  logic              is_rd, acc_ok, acc_rej, acc_nd, done_evt, busy;
  logic [HEAD_W-1:0] head_sel;
  logic              active_q, start_q, irq_q, irq_new_q;
  logic [7:0]        stored_q;
  logic [LBA_W-1:0]  base_q;

  assign is_rd    = is_read_cmd(cmd_byte);
  assign head_sel = HEAD_W'(cmd_byte[1]);
  assign acc_ok   = cmd_stb && is_rd && chs_ok;
  assign acc_rej  = cmd_stb && is_rd && !chs_ok;
  assign acc_nd   = cmd_stb && !is_rd;
  assign done_evt = acc_rej || acc_nd || last_rd;
  assign busy     = active_q && drq;

  geom_regs #(.TRK_W(TRK_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy),
    .tracks_d(cfg_tracks), .heads_d(cfg_heads), .spt_d(cfg_spt),
    .tracks_q(g_tracks), .heads_q(g_heads), .spt_q(g_spt));

  chs_check #(.TRK_W(TRK_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .LBA_W(LBA_W)) u_chs (
    .trk(trk_reg), .head(head_sel), .sec(sec_reg), .multi(cmd_byte[4]),
    .g_tracks(g_tracks), .g_heads(g_heads), .g_spt(g_spt),
    .trk_bad(trk_bad), .head_bad(head_bad), .sec_bad(sec_bad), .ok(chs_ok),
    .lba_base(lba_base), .nsec(nsec));

  xfer_track #(.SEC_W(SEC_W), .BYTES_PER_SEC(BYTES_PER_SEC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .new_cmd(cmd_stb), .load(acc_ok), .nsec(nsec),
    .rd(data_rd), .drq(drq), .last_rd(last_rd), .step_rd(step_rd), .sec_idx(sec_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      stored_q  <= '0;
      base_q    <= '0;
      start_q   <= 1'b0;
      irq_q     <= 1'b0;
      irq_new_q <= 1'b0;
    end else begin
      start_q   <= acc_ok || step_rd;
      irq_new_q <= done_evt && !irq_q;
      if (done_evt)     irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
      if (cmd_stb) begin
        active_q <= acc_ok;
        if (acc_ok) base_q <= lba_base;
        stored_q <= acc_rej ? status_bit(ST_RNF) : status_bit(ST_BUSY);
      end else if (last_rd) begin
        stored_q <= '0;
      end else if (stat_rd && !active_q) begin
        stored_q <= stored_q & ~status_bit(ST_BUSY);
      end
    end
  end

  always_comb begin
    if (active_q) status_o = (stored_q & 8'hFC) | (drq ? status_bit(ST_DRQ) : 8'h00);
    else          status_o = stored_q;
  end

  assign lba_o     = base_q + LBA_W'(sec_idx);
  assign start_o   = start_q;
  assign irq_o     = irq_q;
  assign irq_new_o = irq_new_q;

  // R4: a rejected request reports record-not-found and starts nothing
  a_r4_reject_status: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rej |=> (status_o == 8'h10 && !start_o));
  // R2: an out-of-range track never produces a start
  a_r2_track_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && is_rd && trk_bad) |=> !start_o);
  // R6: during a transfer the request bit follows the pending count, busy masked
  a_r6_drq_view: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (status_o[ST_DRQ] == drq && !status_o[ST_BUSY]));
  // R7: a mid-command start request steps the block number by one
  a_r7_lba_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !$past(cmd_stb)) |-> (lba_o == $past(lba_o) + LBA_W'(1)));
  // R8: a fresh edge is flagged only when the line was low
  a_r8_new_edge: assert property (@(posedge clk) disable iff (!rst_n)
    irq_new_o |-> (irq_o && !$past(irq_o)));
endmodule

// File: tb/sector_cmd_check_test.sv
module sector_cmd_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8, HW = 2, SW = 8, LW = 20, BPS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cmd_stb = 0, data_rd = 0, stat_rd = 0;
  logic [TW-1:0] cfg_tracks = '0, trk_reg = '0;
  logic [HW-1:0] cfg_heads = '0;
  logic [SW-1:0] cfg_spt = '0, sec_reg = '0;
  logic [7:0] cmd_byte = '0;
  logic [7:0] status_o;
  logic [LW-1:0] lba_o;
  logic start_o, irq_o, irq_new_o;

  int compared = 0, mismatched = 0;
  int exp_q[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_cmd_check #(.TRK_W(TW), .HEAD_W(HW), .SEC_W(SW), .LBA_W(LW),
    .BYTES_PER_SEC(BPS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tracks(cfg_tracks),
    .cfg_heads(cfg_heads), .cfg_spt(cfg_spt), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .trk_reg(trk_reg), .sec_reg(sec_reg), .data_rd(data_rd), .stat_rd(stat_rd),
    .status_o(status_o), .lba_o(lba_o), .start_o(start_o), .irq_o(irq_o),
    .irq_new_o(irq_new_o));

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // scoreboard monitor: every start request pops one expected block number
  always @(negedge clk) begin
    if (rst_n && start_o) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R1/R7 unexpected start: actual lba %0d expected none", lba_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(lba_o) != e) begin
          mismatched++;
          $display("FAIL R1/R7 start lba: actual %0d expected %0d", lba_o, e);
        end
      end
    end
  end

  task automatic cfg(input int t, input int h, input int s);
    @(negedge clk); cfg_we = 1; cfg_tracks = TW'(t); cfg_heads = HW'(h); cfg_spt = SW'(s);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cmd(input logic [7:0] c, input int t, input int s);
    @(negedge clk); cmd_stb = 1; cmd_byte = c; trk_reg = TW'(t); sec_reg = SW'(s);
    @(negedge clk); cmd_stb = 0;
  endtask

  // driver for read commands: computes the expected block numbers itself
  task automatic rd_cmd(input logic [7:0] c, input int t, input int s,
                        input int nt, input int nh, input int ns);
    int h, n;
    h = c[1];
    if (t < nt && h < nh && s >= 1 && s <= ns) begin
      n = c[4] ? (ns - s + 1) : 1;
      for (int i = 0; i < n; i++) exp_q.push_back(t*nh*ns + h*ns + s - 1 + i);
    end
    cmd(c, t, s);
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_rd = 1;
      @(negedge clk); data_rd = 0;
    end
  endtask

  task automatic srd();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset status", status_o, 8'h00);
    chk("R8 reset irq", irq_o, 0);
    chk("R1 reset start", start_o, 0);

    cfg(40, 2, 9);
    // single read, head 1 from bit 1
    rd_cmd(8'h82, 5, 3, 40, 2, 9);
    chk("R1 lba single head1", lba_o, 101);
    chk("R6 drq during xfer", status_o, 8'h02);
    rd(3);
    chk("R6 drq before last byte", status_o, 8'h02);
    chk("R8 no irq mid xfer", irq_o, 0);
    rd(1);
    chk("R6 status at completion", status_o, 8'h00);
    chk("R8 irq on completion", irq_o, 1);
    chk("R8 new edge flagged", irq_new_o, 1);
    rd(1);
    chk("R8 new edge one cycle", irq_new_o, 0);
    chk("R5 extra read ignored status", status_o, 8'h00);
    chk("R5 extra read ignored lba", lba_o, 101);
    srd();
    chk("R8 stat read clears irq", irq_o, 0);

    // multi-sector read ending at last sector
    rd_cmd(8'h90, 0, 8, 40, 2, 9);
    rd(4);
    chk("R7 lba steps to next sector", lba_o, 8);
    chk("R5 second sector still pending", status_o, 8'h02);
    rd(4);
    chk("R5 multi length complete", status_o, 8'h00);
    chk("R8 irq after multi", irq_o, 1);
    srd();

    // last valid cylinder/head/sector
    rd_cmd(8'h82, 39, 9, 40, 2, 9);
    chk("R2 last track accepted", lba_o, 719);
    rd(4);
    srd();

    // rejections
    rd_cmd(8'h80, 40, 1, 40, 2, 9);
    chk("R2 track past end rejected", status_o, 8'h10);
    chk("R8 reject raises irq", irq_o, 1);
    chk("R8 reject new edge", irq_new_o, 1);
    rd_cmd(8'h80, 0, 0, 40, 2, 9);
    chk("R4 sector zero rejected", status_o, 8'h10);
    chk("R8 no new edge while pending", irq_new_o, 0);
    chk("R8 line stays high", irq_o, 1);
    rd_cmd(8'h80, 0, 10, 40, 2, 9);
    chk("R4 sector past spt rejected", status_o, 8'h10);
    rd(1);
    chk("R5 read after reject ignored", status_o, 8'h10);
    srd();
    chk("R8 cleared after rejects", irq_o, 0);

    cfg(40, 1, 9);
    rd_cmd(8'h82, 0, 1, 40, 1, 9);
    chk("R3 head past end rejected", status_o, 8'h10);
    rd_cmd(8'h80, 0, 1, 40, 1, 9);
    chk("R3 head zero accepted", status_o, 8'h02);
    rd(4);
    srd();

    // command with no data transfer
    cmd(8'h00, 0, 0);
    chk("R9 nondata busy shown", status_o, 8'h01);
    chk("R9 nondata irq", irq_o, 1);
    chk("R9 nondata new edge", irq_new_o, 1);
    srd();
    chk("R9 status read clears busy", status_o, 8'h00);
    chk("R9 irq cleared", irq_o, 0);

    // geometry write during transfer is ignored
    rd_cmd(8'h80, 1, 1, 40, 1, 9);
    chk("R1 lba track1 one head", lba_o, 9);
    rd(1);
    cfg(40, 1, 5);
    rd(3);
    srd();
    rd_cmd(8'h80, 0, 7, 40, 1, 9);
    chk("R10 old spt kept", status_o, 8'h02);
    rd(4);
    srd();
    cfg(40, 1, 5);
    rd_cmd(8'h80, 0, 7, 40, 1, 5);
    chk("R10 idle write applies", status_o, 8'h10);
    chk("R6 bit6 zero", int'(status_o[6]), 0);

    repeat (3) @(negedge clk);
    chk("R7 all expected starts seen", exp_q.size(), 0);
    summary();
  end
endmodule